// File: doc/BRIEF.md
# Cartridge IRQ Interval Counter

This block is the interrupt timer of a cartridge bank controller that sits on an 8-bit console bus. It watches the CPU phase clock M2, sampled on the system clock, and counts its falling edges. A single control bit comes from a CPU register write and selects one of two states. In the held state the count is cleared and no interrupt can be raised. In the running state the count advances on each falling edge.

The interrupt output is active-low. It is driven low whenever three internal divider taps are all high at once. The taps have periods of 1280, 5120 and 40960 edges, they all advance from the same edge stream, and each one toggles every half period. The output therefore first goes low 23680 edges after release. It goes high again by itself 640 edges later, and software never writes an acknowledge. The pattern repeats for as long as the counter runs.

Address decoding lives in the surrounding controller, and it presents the control bit together with a write strobe. After reset the block is in the held state, the same as if a 1 had been written.

Top module: `cart_irq_timer`

## Requirements
- R1: After reset, `irq_n` is 1 and the block is held: falling edges of `m2` do not advance the count until a 0 is written.
- R2: When the block is running, the count advances once on each falling edge of `m2`, which is a clock edge where `m2` is sampled 0 after it was sampled 1 on the edge before. Rising edges and steady levels do not advance it.
- R3: After a write of 0, `irq_n` stays 1 through 23679 falling edges and is 0 in the cycle after the 23680th.
- R4: `irq_n` returns to 1 in the cycle after the 24320th falling edge, with no write needed.
- R5: While running, `irq_n` is 0 exactly when (n mod 1280) ≥ 640, (n mod 5120) ≥ 2560 and (n mod 40960) ≥ 20480, where n is the number of edges since release. It goes low again after edge 24960.
- R6: A write of 1 (`wr_en`=1, `wr_bit`=1) drives `irq_n` to 1 in the next cycle, even while it is low. It also clears the count, so the next release counts from zero again.
- R7: While held, `m2` edges have no effect: `irq_n` stays 1 and the count stays at zero.
- R8: `wr_bit` is taken only in a cycle where `wr_en` is 1. Changes of `wr_bit` at other times leave the count and `irq_n` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; `m2` is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| m2 | input | 1 | CPU phase clock, treated as a level sampled on `clk` |
| wr_en | input | 1 | One-cycle strobe from the register decoder |
| wr_bit | input | 1 | Control bit: 1 holds and clears, 0 runs |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that `m2` is already synchronous to `clk` and stays at each level for at least one clock cycle. They also assume that `wr_en` is a single-cycle strobe. The stimulus changes `m2` and the write inputs only on the falling clock edge, and it holds each half-phase of `m2` for a full clock cycle. Writes are kept apart from falling edges of `m2`, so the case where a write and an edge land in the same cycle is never exercised. The behavioural model counts edges with plain integers and computes the expected output with modulo arithmetic, so it does not copy the toggle dividers.

// File: rtl/cart_irq_pkg.sv
package cart_irq_pkg;
  localparam int unsigned NUM_TAPS = 3;
  typedef logic [NUM_TAPS-1:0] tap_vec_t;
endpackage

// File: rtl/cirq_rst_sync.sv
module cirq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cirq_edge_det.sv
module cirq_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fall
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign fall = lvl_q & ~lvl;
endmodule

// File: rtl/cirq_tap_div.sv
module cirq_tap_div #(
  parameter int unsigned PERIOD = 1280
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tap
);
  localparam int unsigned HALF = PERIOD / 2;
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tap_q, tap_d;

  always_comb begin
    cnt_d = cnt_q;
    tap_d = tap_q;
    if (clr) begin
      cnt_d = '0;
      tap_d = 1'b0;
    end else if (en) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        tap_d = ~tap_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tap_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tap_q <= tap_d;
    end
  end

  assign tap = tap_q;

  // R5
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R7
  tap_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(tap_q));
endmodule

// File: rtl/cart_irq_timer.sv
module cart_irq_timer #(
  parameter int unsigned TAP_PERIOD [cart_irq_pkg::NUM_TAPS] = '{1280, 5120, 40960}
) (
  input  logic clk,
  input  logic rst_n,
  input  logic m2,
  input  logic wr_en,
  input  logic wr_bit,
  output logic irq_n
);
  import cart_irq_pkg::*;

  logic     rst_sync_n;
  logic     m2_fall;
  logic     hold_q, hold_d;
  logic     div_clr, div_en;
  tap_vec_t taps;

  cirq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cirq_edge_det u_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .lvl   (m2),
    .fall  (m2_fall)
  );

  always_comb begin
    hold_d  = wr_en ? wr_bit : hold_q;
    div_clr = hold_d;
    div_en  = ~hold_d & m2_fall;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) hold_q <= 1'b1;
    else             hold_q <= hold_d;
  end

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    cirq_tap_div #(.PERIOD(TAP_PERIOD[i])) u_div (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .clr   (div_clr),
      .en    (div_en),
      .tap   (taps[i])
    );
  end

  assign irq_n = ~(&taps);

  // R6
  held_irq_high_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hold_q |-> irq_n);

  // R6
  set_releases_irq_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_bit) |=> irq_n);

  // R2
  irq_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(irq_n) |-> $past(m2_fall));

  // R8
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_en |=> $stable(hold_q));
endmodule

// File: tb/cart_irq_timer_test.sv
module cart_irq_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m2 = 1'b0;
  logic wr_en = 1'b0;
  logic wr_bit = 1'b0;
  logic irq_n;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;

  // reference model state
  int  ref_edges = 0;
  bit  ref_hold = 1'b1;
  bit  ref_prev = 1'b0;

  always #10 clk = ~clk;

  cart_irq_timer uut (
    .clk(clk), .rst_n(rst_n), .m2(m2),
    .wr_en(wr_en), .wr_bit(wr_bit), .irq_n(irq_n)
  );

  function automatic bit ref_irq_n(int n, bit held);
    if (held) return 1'b1;
    return !(((n % 1280) >= 640) && ((n % 5120) >= 2560) && ((n % 40960) >= 20480));
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      ref_edges = 0; ref_hold = 1'b1; ref_prev = 1'b0;
    end else begin
      if (wr_en) ref_hold = wr_bit;
      if (ref_hold) ref_edges = 0;
      else if (ref_prev && !m2) ref_edges++;
      ref_prev = m2;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if (irq_n !== ref_irq_n(ref_edges, ref_hold)) begin
        fails++;
        $display("FAIL R5 model compare edge %0d: irq_n=%b expected %b",
                 ref_edges, irq_n, ref_irq_n(ref_edges, ref_hold));
      end
    end
  end

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: irq_n=%b expected %b (edge %0d)", req, act, exp, ref_edges);
    end
  endtask

  task automatic edges(int n);
    for (int k = 0; k < n; k++) begin
      m2 = 1'b1; @(negedge clk);
      m2 = 1'b0; @(negedge clk);
    end
  endtask

  task automatic write_ctl(bit v);
    wr_bit = v; wr_en = 1'b1; @(negedge clk);
    wr_en = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, got %0d expected finish", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;
    check("R1 reset idle", irq_n, 1'b1);
    // R1, R7: edges while held after reset do nothing
    edges(700);
    check("R1 held after reset", irq_n, 1'b1);
    check("R7 held ignores m2", irq_n, 1'b1);

    write_ctl(1'b0);
    edges(100);
    // R8: wr_bit toggles without strobe, must be ignored
    wr_bit = 1'b1; repeat (3) @(negedge clk); wr_bit = 1'b0;
    edges(23579);
    check("R3 before first fire", irq_n, 1'b1);
    check("R8 stray wr_bit ignored", irq_n, 1'b1);
    edges(1);
    check("R3 fire at 23680", irq_n, 1'b0);
    check("R2 falling edges counted", irq_n, 1'b0);
    edges(639);
    check("R4 still low at 24319", irq_n, 1'b0);
    edges(1);
    check("R4 self release at 24320", irq_n, 1'b1);
    edges(639);
    check("R5 high at 24959", irq_n, 1'b1);
    edges(1);
    check("R5 refire at 24960", irq_n, 1'b0);
    write_ctl(1'b1);
    check("R6 set releases irq", irq_n, 1'b1);
    edges(500);
    check("R7 held stays high", irq_n, 1'b1);

    write_ctl(1'b0);
    edges(23679);
    check("R6 count restarted", irq_n, 1'b1);
    edges(1);
    check("R6 fire after restart", irq_n, 1'b0);
    edges(20);
    wr_bit = 1'b1; wr_en = 1'b1; @(negedge clk);
    wr_en = 1'b0;
    check("R6 immediate release while active", irq_n, 1'b1);
    edges(50);
    check("R7 cleared and held", irq_n, 1'b1);

    cmp_on = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule